// File: doc/BRIEF.md
# Mask-Guided Sparse Partial-Sum Accumulator

A convolution layer too large for one crossbar is split into segments. Each segment produces one rectified, non-negative partial sum per output channel. Most of these are zero, so a source hands each segment over as an occupancy mask with one bit per channel. Next to the mask it sends a packed list that holds only the non-zero values. This block adds the segments together channel by channel. It walks the mask of the segment on offer and uses one clock per set bit. A cleared bit costs nothing: no value is read and no add happens.

A run begins with a start pulse that carries the number of segments. The source then offers segments one at a time on a valid line. The block pulses a take signal in the cycle it finishes the segment on offer, and the source moves on to the next one. After the last segment is consumed, a one-cycle done pulse follows. The per-channel totals then hold until the next start. An active-cycle counter shows that the latency tracks the number of non-zero entries and not segments times channels.

Top module: `sparse_psum_acc`

## Requirements
- R1: After a run, each channel's total equals the sum, over all consumed segments, of that channel's value in each segment whose mask bit for that channel is set.
- R2: In the packed vector, entry k (bits k*VAL_W up to k*VAL_W+VAL_W-1) belongs to the k-th lowest set bit of the mask. Entries beyond the number of set bits have no effect on any total.
- R3: Totals are unsigned and ACC_W = VAL_W + clog2(MAX_SEG) bits wide. MAX_SEG segments that all carry the largest value in every channel give the exact total with no wrap.
- R4: While running with seg_valid_i high, each cycle consumes exactly one set mask bit. A segment therefore takes max(popcount(mask), 1) cycles, and cyc_cnt_o counts these active cycles for the whole run.
- R5: A segment whose mask is all zero is consumed in a single cycle, with seg_take_o high in that cycle.
- R6: seg_take_o is high only in a running cycle with seg_valid_i high, and only in the cycle that finishes the segment on offer. Cycles with seg_valid_i low make no progress and are not counted.
- R7: A start_i while idle clears all totals and cyc_cnt_o on the next edge and latches seg_count_i. Counts above MAX_SEG are treated as MAX_SEG.
- R8: done_o is high for exactly one cycle, in the cycle after the edge that consumes the last segment. busy_o is low in that cycle.
- R9: While idle, totals and cyc_cnt_o hold their values, and segment inputs are ignored (seg_take_o stays low).
- R10: start_i while busy is ignored. The run in progress completes with its original segment count and totals.
- R11: A start with seg_count_i of zero gives done_o in the cycle after start, with all totals zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (taken only while idle) |
| seg_count_i | input | SEG_W | Number of segments in the run |
| seg_valid_i | input | 1 | A segment is on offer |
| seg_mask_i | input | N_CH | Occupancy mask, bit c = channel c non-zero |
| seg_vals_i | input | N_CH*VAL_W | Packed non-zero values, lowest channel first |
| seg_take_o | output | 1 | The segment on offer is finished at this edge |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| acc_o | output | N_CH*ACC_W | Per-channel totals, channel c at bits c*ACC_W |
| cyc_cnt_o | output | CYC_W | Active accumulation cycles of the current or last run |

## Verification
The bench builds the block with 8 channels, 4-bit values and up to 16 segments, so ACC_W is 8 bits. At these values a run of all sixteen segments at the value 15 reaches 240, which checks the no-wrap width bound exactly, and a count of 20 reaches the clamp. Eight channels are enough for full, empty and scattered masks, so the lowest-bit walk, the pointer into the packed list and the unused trailing entries (filled with 15) all come into play. The bench also uses stall gaps on the valid line and sends a start in the middle of a run.

// File: rtl/psa_pkg.sv
package psa_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } psa_state_e;
endpackage

// File: rtl/psa_lead_enc.sv
// Lowest set bit of req_i, resolved in one cycle.
module psa_lead_enc #(
  parameter int N   = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/psa_pack_sel.sv
// Picks one entry of the packed non-zero list.
module psa_pack_sel #(
  parameter int N     = 8,
  parameter int VAL_W = 4,
  localparam int PW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*VAL_W-1:0] vals_i,
  input  logic [PW-1:0]      ptr_i,
  output logic [VAL_W-1:0]   val_o
);
  assign val_o = vals_i[ptr_i*VAL_W +: VAL_W];
endmodule

// File: rtl/psa_acc_bank.sv
module psa_acc_bank #(
  parameter int N     = 8,
  parameter int VAL_W = 4,
  parameter int ACC_W = 8,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               en_i,
  input  logic [IW-1:0]      ch_i,
  input  logic [VAL_W-1:0]   val_i,
  output logic [N*ACC_W-1:0] acc_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic [ACC_W-1:0] acc_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         acc_q <= '0;
      else if (clr_i)                      acc_q <= '0;
      else if (en_i && ch_i == IW'(g))     acc_q <= acc_q + ACC_W'(val_i);
    end
    assign acc_o[g*ACC_W +: ACC_W] = acc_q;
  end
endmodule

// File: rtl/sparse_psum_acc.sv
module sparse_psum_acc
  import psa_pkg::*;
#(
  parameter int N_CH    = 8,
  parameter int VAL_W   = 4,
  parameter int MAX_SEG = 16,
  localparam int SEG_W  = $clog2(MAX_SEG + 1),
  localparam int ACC_W  = VAL_W + $clog2(MAX_SEG),
  localparam int CYC_W  = $clog2(MAX_SEG * N_CH + 1),
  localparam int IW     = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [SEG_W-1:0]      seg_count_i,
  input  logic                  seg_valid_i,
  input  logic [N_CH-1:0]       seg_mask_i,
  input  logic [N_CH*VAL_W-1:0] seg_vals_i,
  output logic                  seg_take_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [N_CH*ACC_W-1:0] acc_o,
  output logic [CYC_W-1:0]      cyc_cnt_o
);
  psa_state_e       state_q;
  logic [SEG_W-1:0] seg_num_q, seg_idx_q, seg_cnt_clamp;
  logic [N_CH-1:0]  used_q, rem, hit_oh;
  logic [IW-1:0]    ptr_q, hit_ch;
  logic [CYC_W-1:0] cyc_q;
  logic [VAL_W-1:0] cur_val;
  logic             done_q, hit_any, start_ok, step, last_bit, seg_fin, run_fin;

  assign rem      = seg_mask_i & ~used_q;
  assign start_ok = start_i && (state_q == ST_IDLE);
  assign step     = (state_q == ST_RUN) && seg_valid_i;
  // zero or one bit left: this cycle finishes the segment
  assign last_bit = (rem & (rem - N_CH'(1))) == '0;
  assign seg_fin  = step && last_bit;
  assign run_fin  = seg_fin && (seg_idx_q == seg_num_q - SEG_W'(1));
  assign seg_cnt_clamp = (seg_count_i > SEG_W'(MAX_SEG)) ? SEG_W'(MAX_SEG) : seg_count_i;

  psa_lead_enc #(.N(N_CH)) u_enc (
    .req_i (rem),
    .idx_o (hit_ch),
    .any_o (hit_any)
  );

  psa_pack_sel #(.N(N_CH), .VAL_W(VAL_W)) u_sel (
    .vals_i (seg_vals_i),
    .ptr_i  (ptr_q),
    .val_o  (cur_val)
  );

  psa_acc_bank #(.N(N_CH), .VAL_W(VAL_W), .ACC_W(ACC_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_ok),
    .en_i   (step && hit_any),
    .ch_i   (hit_ch),
    .val_i  (cur_val),
    .acc_o  (acc_o)
  );

  always_comb begin
    hit_oh = '0;
    hit_oh[hit_ch] = hit_any;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      seg_num_q <= '0;
      seg_idx_q <= '0;
      used_q    <= '0;
      ptr_q     <= '0;
      cyc_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        seg_num_q <= seg_cnt_clamp;
        seg_idx_q <= '0;
        used_q    <= '0;
        ptr_q     <= '0;
        cyc_q     <= '0;
        if (seg_cnt_clamp == '0) done_q  <= 1'b1;
        else                     state_q <= ST_RUN;
      end else if (step) begin
        cyc_q <= cyc_q + CYC_W'(1);
        if (seg_fin) begin
          used_q    <= '0;
          ptr_q     <= '0;
          seg_idx_q <= seg_idx_q + SEG_W'(1);
          if (run_fin) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end else begin
          used_q <= used_q | hit_oh;
          ptr_q  <= ptr_q + IW'(1);
        end
      end
    end
  end

  assign seg_take_o = seg_fin;
  assign busy_o     = (state_q == ST_RUN);
  assign done_o     = done_q;
  assign cyc_cnt_o  = cyc_q;
endmodule

// File: rtl/psa_accum_chk.sv
module psa_accum_chk #(
  parameter int N_CH  = 8,
  parameter int ACC_W = 8,
  parameter int CYC_W = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  start_i,
  input logic                  seg_valid_i,
  input logic                  seg_take_o,
  input logic                  busy_o,
  input logic                  done_o,
  input logic [N_CH*ACC_W-1:0] acc_o,
  input logic [CYC_W-1:0]      cyc_cnt_o
);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_take_needs_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_take_o |-> (seg_valid_i && busy_o));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(acc_o) && $stable(cyc_cnt_o)));

  assert_clear_on_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (acc_o == '0 && cyc_cnt_o == '0));

  assert_busy_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && !seg_take_o) |=> busy_o);
endmodule

bind sparse_psum_acc psa_accum_chk #(
  .N_CH (N_CH),
  .ACC_W(ACC_W),
  .CYC_W(CYC_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .seg_valid_i(seg_valid_i),
  .seg_take_o (seg_take_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .acc_o      (acc_o),
  .cyc_cnt_o  (cyc_cnt_o)
);

// File: tb/sparse_psum_acc_bench.sv
`timescale 1ns/1ps
module sparse_psum_acc_bench;
  localparam int N_CH = 8, VAL_W = 4, MAX_SEG = 16;
  localparam int SEG_W = $clog2(MAX_SEG + 1);
  localparam int ACC_W = VAL_W + $clog2(MAX_SEG);
  localparam int CYC_W = $clog2(MAX_SEG * N_CH + 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, seg_valid_i = 1'b0;
  logic [SEG_W-1:0] seg_count_i = '0;
  logic [N_CH-1:0] seg_mask_i = '0;
  logic [N_CH*VAL_W-1:0] seg_vals_i = '0;
  logic seg_take_o, busy_o, done_o;
  logic [N_CH*ACC_W-1:0] acc_o;
  logic [CYC_W-1:0] cyc_cnt_o;

  int checks = 0, failures = 0;
  logic [N_CH-1:0] masks [MAX_SEG];
  logic [VAL_W-1:0] dense [MAX_SEG][N_CH];
  int exp_acc [N_CH];
  int exp_cyc;

  always #2.5 clk = ~clk;

  sparse_psum_acc #(.N_CH(N_CH), .VAL_W(VAL_W), .MAX_SEG(MAX_SEG)) u_sparse_psum_acc (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .seg_count_i(seg_count_i),
    .seg_valid_i(seg_valid_i), .seg_mask_i(seg_mask_i), .seg_vals_i(seg_vals_i),
    .seg_take_o(seg_take_o), .busy_o(busy_o), .done_o(done_o),
    .acc_o(acc_o), .cyc_cnt_o(cyc_cnt_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #200000;
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  function automatic int acc_of(input int ch);
    return int'(acc_o[ch*ACC_W +: ACC_W]);
  endfunction

  task automatic check_totals(input string req, input string what);
    for (int c = 0; c < N_CH; c++)
      check(acc_of(c) == exp_acc[c], req, $sformatf("%s ch%0d", what, c), acc_of(c), exp_acc[c]);
  endtask

  // nseg segments presented, cnt given as seg_count; gap idle cycles before each;
  // poke: start pulse during the run
  task automatic run_layer(input int nseg, input int cnt, input int gap, input bit poke,
                           input string req, input string what);
    int pop, k, guard;
    logic [N_CH*VAL_W-1:0] pk;
    for (int c = 0; c < N_CH; c++) exp_acc[c] = 0;
    exp_cyc = 0;
    @(negedge clk);
    start_i = 1'b1; seg_count_i = SEG_W'(cnt);
    @(negedge clk);
    start_i = 1'b0;
    for (int s = 0; s < nseg; s++) begin
      for (int g = 0; g < gap; g++) begin
        seg_valid_i = 1'b0;
        seg_mask_i = ~masks[s];
        if (poke && s == 1 && g == 0) begin start_i = 1'b1; seg_count_i = SEG_W'(1); end
        @(negedge clk);
        start_i = 1'b0;
      end
      pk = '1; k = 0; pop = 0;
      for (int c = 0; c < N_CH; c++) begin
        if (masks[s][c]) begin
          pk[k*VAL_W +: VAL_W] = dense[s][c];
          exp_acc[c] += int'(dense[s][c]);
          k++; pop++;
        end
      end
      exp_cyc += (pop == 0) ? 1 : pop;
      seg_mask_i = masks[s]; seg_vals_i = pk; seg_valid_i = 1'b1;
      #1;
      guard = 0;
      while (!seg_take_o && guard < 40) begin @(negedge clk); #1; guard++; end
      if (pop <= 1)
        check(seg_take_o && guard == 0, "R5", $sformatf("%s seg%0d single-cycle take", what, s),
              guard, 0);
      else
        check(guard == pop - 1, "R4", $sformatf("%s seg%0d cycles", what, s), guard + 1, pop);
      @(negedge clk);
    end
    seg_valid_i = 1'b0;
    check(done_o == 1'b1, "R8", {what, " done after last segment"}, int'(done_o), 1);
    check(busy_o == 1'b0, "R8", {what, " not busy at done"}, int'(busy_o), 0);
    check_totals(req, what);
    check(int'(cyc_cnt_o) == exp_cyc, "R4", {what, " active cycles"}, int'(cyc_cnt_o), exp_cyc);
    @(negedge clk);
    check(done_o == 1'b0, "R8", {what, " done lasts one cycle"}, int'(done_o), 0);
  endtask

  task automatic t_reset();
    check(acc_o == '0, "R9", "reset totals", int'(acc_o != '0), 0);
    check(done_o == 1'b0 && busy_o == 1'b0, "R8", "reset done/busy", int'(done_o | busy_o), 0);
    check(cyc_cnt_o == '0, "R4", "reset cycle count", int'(cyc_cnt_o), 0);
  endtask

  task automatic t_dense();
    for (int s = 0; s < 4; s++) begin
      masks[s] = '1;
      for (int c = 0; c < N_CH; c++) dense[s][c] = VAL_W'((s * 7 + c * 3 + 1) % 16);
    end
    run_layer(4, 4, 0, 1'b0, "R1", "dense");
  endtask

  task automatic t_sparse();
    masks[0] = 8'b1000_0001; masks[1] = 8'b0101_0100; masks[2] = 8'b0000_0000;
    masks[3] = 8'b0010_0000; masks[4] = 8'b1111_0000;
    for (int s = 0; s < 5; s++)
      for (int c = 0; c < N_CH; c++) dense[s][c] = VAL_W'((s * 5 + c * 11 + 2) % 15 + 1);
    run_layer(5, 5, 2, 1'b0, "R2", "sparse stalled");
  endtask

  task automatic t_empty();
    for (int s = 0; s < 6; s++) masks[s] = '0;
    run_layer(6, 6, 0, 1'b0, "R5", "all-empty");
  endtask

  task automatic t_max();
    for (int s = 0; s < MAX_SEG; s++) begin
      masks[s] = '1;
      for (int c = 0; c < N_CH; c++) dense[s][c] = 4'hF;
    end
    // count 20 clamps to 16 (R7); totals reach 240 without wrap (R3)
    run_layer(MAX_SEG, 20, 0, 1'b0, "R3", "max clamp");
  endtask

  task automatic t_zero_count();
    run_layer(0, 0, 0, 1'b0, "R11", "zero count");
  endtask

  task automatic t_busy_start();
    masks[0] = 8'b0000_0110; masks[1] = 8'b1001_0000; masks[2] = 8'b0100_0001;
    for (int s = 0; s < 3; s++)
      for (int c = 0; c < N_CH; c++) dense[s][c] = VAL_W'(c + s + 3);
    run_layer(3, 3, 1, 1'b1, "R10", "start while busy");
  endtask

  task automatic t_idle_hold();
    for (int i = 0; i < 4; i++) begin
      seg_valid_i = 1'b1; seg_mask_i = 8'hA5; seg_vals_i = '1;
      #1;
      check(seg_take_o == 1'b0, "R9", "no take while idle", int'(seg_take_o), 0);
      @(negedge clk);
    end
    seg_valid_i = 1'b0;
    check_totals("R9", "held while idle");
    check(int'(cyc_cnt_o) == exp_cyc, "R9", "cycle count held", int'(cyc_cnt_o), exp_cyc);
    @(negedge clk); start_i = 1'b1; seg_count_i = SEG_W'(2);
    @(negedge clk); start_i = 1'b0;
    check(acc_o == '0 && cyc_cnt_o == '0, "R7", "clear on start",
          int'(acc_o != '0) + int'(cyc_cnt_o), 0);
    check(busy_o == 1'b1, "R7", "busy after start", int'(busy_o), 1);
    masks[0] = 8'h01; masks[1] = 8'h00; dense[0][0] = 4'd9;
    exp_acc[0] = 9;
    for (int s = 0; s < 2; s++) begin
      seg_mask_i = masks[s]; seg_vals_i = {{(N_CH*VAL_W-VAL_W){1'b1}}, 4'd9}; seg_valid_i = 1'b1;
      #1; check(seg_take_o == 1'b1, "R6", "take on one-bit segment", int'(seg_take_o), 1);
      @(negedge clk);
    end
    seg_valid_i = 1'b0;
    check(done_o == 1'b1, "R8", "short run done", int'(done_o), 1);
    check(acc_of(0) == 9 && acc_of(7) == 0, "R1", "short run totals", acc_of(0), 9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_dense();
    t_sparse();
    t_empty();
    t_max();
    t_zero_count();
    t_busy_start();
    t_idle_hold();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule